// File: doc/BRIEF.md
# I2S Transmit Master with Dead-Clock Framing

This block drives an I2S bus to a codec that takes 16-bit samples. It generates the bit clock, the word-select (LRCLK) and the serial data line. The frame length is fixed at 48 or 64 bit clocks, and each sample has only 16 bits. Every half-frame is therefore 24 or 32 bit clocks long, and the slots after the sample are dead clocks. The dead clocks are kept on the bus. They are not removed. A receiver finds each channel from the LRCLK edges alone, not by counting packed bits.

The core clock `clk` runs at twice the master-clock rate. This lets a master-clock divide of 1 still come out as a registered bit clock with a 50% duty cycle. A parent block supplies the left/right sample pairs. It supplies each pair with a one-cycle valid pulse, usually in answer to the request strobe that the block raises at the start of every right half. The pair is applied at the next left half. If no pair arrives, the previous pair is sent again. The divider select and the frame length are taken only at frame boundaries.

Top module: `i2s_frame_tx`

## Requirements
- R1: The bit clock has a 50% duty cycle. Each of its phases lasts D cycles of `clk`, so one period equals D master-clock periods. D is set by `cfgDivSel`: 0→1, 1→2, 2→4, 3→8, 4→16, and any code from 5 to 7 also gives 16.
- R2: A frame is 48 bit-clock periods when `cfgRatioLong`=0 and 64 when it is 1. LRCLK is low for the first half of the frame (left channel) and high for the second half (right channel). A frame starts when LRCLK falls.
- R3: In each half, bit-clock slot 0 comes after the LRCLK edge. Slots 1 to 16 carry the 16-bit sample, most significant bit first. The data is valid at the rising bit-clock edge.
- R4: Slot 0 and every slot after slot 16 are dead clocks. The data line is driven 0 during them, and the bit clock keeps toggling.
- R5: LRCLK and the serial data change only in the `clk` cycle in which the bit clock falls.
- R6: A pair presented with `inValid` is held and sent in the next frame, starting with that frame's left half. If no pair has arrived since the last frame start, the previous pair is sent again.
- R7: `sampleReq` is a one-cycle pulse. It is raised in the same cycle as the LRCLK rise that starts each right half.
- R8: `cfgDivSel` and `cfgRatioLong` are sampled only at a frame start, and while reset is held. Changes in the middle of a frame have no effect until the next frame.
- R9: While reset is held, the bit clock, LRCLK, data and `sampleReq` are low. The first frame after reset carries the pair 0/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| cfgDivSel | input | 3 | Bit-clock divider select |
| cfgRatioLong | input | 1 | Frame length select: 0 gives 48 bit clocks, 1 gives 64 |
| inValid | input | 1 | One-cycle strobe that delivers a sample pair |
| inLeft | input | 16 | Left sample |
| inRight | input | 16 | Right sample |
| sampleReq | output | 1 | Pulse that asks for the next pair |
| bclkOut | output | 1 | Bit clock |
| lrclkOut | output | 1 | Word select: low for left, high for right |
| sdataOut | output | 1 | Serial data |

## Verification
The hardest case to reach is a configuration change in the middle of a frame that must not take effect until LRCLK next falls. The phase lengths of the last bit clock of the old frame and the first bit clock of the new frame must then follow different dividers. The stimulus reaches this case by changing the divider and the frame length at random points after each request, so some changes land late in a right half and some land early in a left half. The bench samples the configuration at every core-clock edge so that it knows exactly which value the frame boundary took. One request is left unanswered on purpose so that the repeated-pair path runs, and the code 7 is used so that the divider clamp runs.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // Per-bit-clock control strobes, all asserted in the cycle the bit clock falls.
  typedef struct packed {
    logic loadLeft;   // entering slot 0 of the left half (frame start)
    logic loadRight;  // entering slot 0 of the right half
    logic shiftBit;   // entering a sample slot (1..sample width)
    logic deadBit;    // entering a padding slot after the sample
  } txStrobe_t;

  // Divider value for a select code, clamped to 2**maxLog.
  function automatic int unsigned divFromSel(int unsigned sel, int unsigned maxLog);
    return (sel > maxLog) ? (32'd1 << maxLog) : (32'd1 << sel);
  endfunction

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int DIV_SEL_W   = 3,
  parameter int MAX_DIV_LOG = 4,
  parameter int RATIO_SHORT = 48,
  parameter int RATIO_LONG  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_SEL_W-1:0] cfgDivSel,
  input  logic                 cfgRatioLong,
  output txStrobe_t            strobe,
  output logic                 bclkOut,
  output logic                 lrclkOut,
  output logic                 sampleReq
);

  localparam int CNT_W  = MAX_DIV_LOG + 1;
  localparam int SLOT_W = $clog2(RATIO_LONG);

  logic [DIV_SEL_W-1:0] divSelAct;
  logic                 ratioLongAct;
  logic [CNT_W-1:0]     halfCnt;
  logic [CNT_W-1:0]     divVal;
  logic [SLOT_W-1:0]    slot;
  logic [SLOT_W-1:0]    nextSlot;
  logic [SLOT_W-1:0]    nextPos;
  logic [SLOT_W-1:0]    frameLast;
  logic [SLOT_W-1:0]    halfLen;
  logic                 bclkR;
  logic                 lrR;
  logic                 reqR;
  logic                 phaseEnd;
  logic                 fallNow;
  logic                 inSample;

  always_comb begin
    divVal    = CNT_W'(divFromSel(int'(divSelAct), MAX_DIV_LOG));
    frameLast = ratioLongAct ? SLOT_W'(RATIO_LONG - 1) : SLOT_W'(RATIO_SHORT - 1);
    halfLen   = ratioLongAct ? SLOT_W'(RATIO_LONG / 2) : SLOT_W'(RATIO_SHORT / 2);
    phaseEnd  = (halfCnt == divVal - CNT_W'(1));
    fallNow   = phaseEnd && bclkR;
    nextSlot  = (slot == frameLast) ? '0 : slot + SLOT_W'(1);
    nextPos   = (nextSlot >= halfLen) ? nextSlot - halfLen : nextSlot;
    inSample  = (nextPos != '0) && (nextPos <= SLOT_W'(SAMPLE_W));
  end

  always_comb begin
    strobe           = '0;
    strobe.loadLeft  = fallNow && (nextSlot == '0);
    strobe.loadRight = fallNow && (nextSlot == halfLen);
    strobe.shiftBit  = fallNow && inSample;
    strobe.deadBit   = fallNow && !inSample && (nextPos != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halfCnt      <= '0;
      bclkR        <= 1'b0;
      slot         <= '0;
      lrR          <= 1'b0;
      reqR         <= 1'b0;
      divSelAct    <= cfgDivSel;
      ratioLongAct <= cfgRatioLong;
    end else begin
      reqR <= strobe.loadRight;
      if (phaseEnd) begin
        halfCnt <= '0;
        bclkR   <= ~bclkR;
      end else begin
        halfCnt <= halfCnt + CNT_W'(1);
      end
      if (fallNow) begin
        slot <= nextSlot;
        lrR  <= (nextSlot >= halfLen);
        if (nextSlot == '0) begin
          divSelAct    <= cfgDivSel;
          ratioLongAct <= cfgRatioLong;
        end
      end
    end
  end

  assign bclkOut   = bclkR;
  assign lrclkOut  = lrR;
  assign sampleReq = reqR;

  p_lr_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrR) |-> $fell(bclkR));

  p_req_single_r7: assert property (@(posedge clk) disable iff (rst)
    reqR |=> !reqR);

  p_req_with_right_r7: assert property (@(posedge clk) disable iff (rst)
    reqR |-> $rose(lrR));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(divSelAct) || !$stable(ratioLongAct)) |-> (slot == '0 && $fell(bclkR)));

  p_frame_left_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(lrR) |-> (slot == '0));

endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  txStrobe_t           strobe,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                sdataOut
);

  logic [SAMPLE_W-1:0] pendL, pendR;
  logic                pendFull;
  logic [SAMPLE_W-1:0] actL, actR;
  logic [SAMPLE_W-1:0] shReg;
  logic                sdR;

  // One-entry holding buffer; a new pair overwrites an unconsumed one.
  always_ff @(posedge clk) begin
    if (rst) begin
      pendL    <= '0;
      pendR    <= '0;
      pendFull <= 1'b0;
    end else if (inValid) begin
      pendL    <= inLeft;
      pendR    <= inRight;
      pendFull <= 1'b1;
    end else if (strobe.loadLeft) begin
      pendFull <= 1'b0;
    end
  end

  // Active pair and serializer.
  always_ff @(posedge clk) begin
    if (rst) begin
      actL  <= '0;
      actR  <= '0;
      shReg <= '0;
      sdR   <= 1'b0;
    end else begin
      if (strobe.loadLeft) begin
        sdR <= 1'b0;
        if (pendFull) begin
          actL  <= pendL;
          actR  <= pendR;
          shReg <= pendL;
        end else begin
          shReg <= actL;
        end
      end else if (strobe.loadRight) begin
        sdR   <= 1'b0;
        shReg <= actR;
      end else if (strobe.shiftBit) begin
        sdR   <= shReg[SAMPLE_W-1];
        shReg <= {shReg[SAMPLE_W-2:0], 1'b0};
      end else if (strobe.deadBit) begin
        sdR <= 1'b0;
      end
    end
  end

  assign sdataOut = sdR;

  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  p_dead_low_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.deadBit |=> !sdR);

  p_data_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdR) |-> $past(|strobe));

  p_pend_consumed_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadLeft && pendFull && !inValid) |=> !pendFull);

endmodule

// File: rtl/i2s_frame_tx.sv
module i2s_frame_tx
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int DIV_SEL_W   = 3,
  parameter int MAX_DIV_LOG = 4,
  parameter int RATIO_SHORT = 48,
  parameter int RATIO_LONG  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_SEL_W-1:0] cfgDivSel,
  input  logic                 cfgRatioLong,
  input  logic                 inValid,
  input  logic [SAMPLE_W-1:0]  inLeft,
  input  logic [SAMPLE_W-1:0]  inRight,
  output logic                 sampleReq,
  output logic                 bclkOut,
  output logic                 lrclkOut,
  output logic                 sdataOut
);

  txStrobe_t strobe;

  i2s_tx_ctrl #(
    .SAMPLE_W   (SAMPLE_W),
    .DIV_SEL_W  (DIV_SEL_W),
    .MAX_DIV_LOG(MAX_DIV_LOG),
    .RATIO_SHORT(RATIO_SHORT),
    .RATIO_LONG (RATIO_LONG)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .cfgDivSel   (cfgDivSel),
    .cfgRatioLong(cfgRatioLong),
    .strobe      (strobe),
    .bclkOut     (bclkOut),
    .lrclkOut    (lrclkOut),
    .sampleReq   (sampleReq)
  );

  i2s_tx_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inValid (inValid),
    .inLeft  (inLeft),
    .inRight (inRight),
    .sdataOut(sdataOut)
  );

endmodule

// File: tb/i2s_frame_tx_test.sv
module i2s_frame_tx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfgDivSel = 3'd0;
  logic        cfgRatioLong = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inLeft = 16'd0;
  logic [15:0] inRight = 16'd0;
  logic        sampleReq, bclkOut, lrclkOut, sdataOut;

  always #5 clk = ~clk;

  i2s_frame_tx uut (
    .clk(clk), .rst(rst), .cfgDivSel(cfgDivSel), .cfgRatioLong(cfgRatioLong),
    .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .sampleReq(sampleReq), .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdataOut(sdataOut)
  );

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int divOf(input logic [2:0] s);
    return (s >= 3'd4) ? 16 : (1 << s);
  endfunction

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  logic [3:0] cfgAtEdge = 4'd0;
  always @(posedge clk) begin
    cfgAtEdge <= {cfgDivSel, cfgRatioLong};
    cycles <= cycles + 1;
  end

  // Bench model state
  bit          monOn = 0;
  logic        prevB = 0, prevLr = 0, prevSd = 0;
  int          lowLen, highLen, curDiv, curRatio, frameRises;
  int          halfSlot, halfLenExp, deadBad, halfFrame, framesDone;
  logic        lrAtHalf;
  logic [15:0] halfWord, halfExp, expL, expR, pendL, pendR;
  bit          pendFull;

  task automatic finishHalf();
    check(halfSlot + 1 == halfLenExp, "R2 half length", halfSlot + 1, halfLenExp);
    if (halfFrame == 0)
      check(halfWord == halfExp, "R9 first frame data", halfWord, halfExp);
    else if (lrAtHalf)
      check(halfWord == halfExp, "R3 R6 right sample", halfWord, halfExp);
    else
      check(halfWord == halfExp, "R3 R6 left sample", halfWord, halfExp);
    check(deadBad == 0, "R4 dead clocks low", deadBad, 0);
  endtask

  always @(negedge clk) begin : mon
    logic b, lr, sd;
    bit rise, fall;
    b = bclkOut; lr = lrclkOut; sd = sdataOut;
    rise = b && !prevB;
    fall = !b && prevB;
    if (monOn && !rst) begin
      if (lr !== prevLr || sd !== prevSd)
        check(fall, "R5 change off falling edge", fall, 1);
      if (sampleReq || (fall && lr && !prevLr))
        check(sampleReq && fall && lr && !prevLr, "R7 request pulse", sampleReq, 1);
      if (rise) begin
        check(lowLen == curDiv, "R1 R8 low phase", lowLen, curDiv);
        highLen = 1;
        frameRises++;
        if (halfSlot < 0 || lr !== lrAtHalf) begin
          if (halfSlot >= 0) finishHalf();
          halfSlot = 0;
          lrAtHalf = lr;
          halfExp = lr ? expR : expL;
          halfLenExp = curRatio / 2;
          halfWord = 16'd0;
          deadBad = 0;
          halfFrame = framesDone;
        end else begin
          halfSlot++;
        end
        if (halfSlot >= 1 && halfSlot <= 16) halfWord[16 - halfSlot] = sd;
        else if (sd) deadBad++;
      end else if (b) begin
        highLen++;
      end
      if (fall) begin
        check(highLen == curDiv, "R1 high phase", highLen, curDiv);
        lowLen = 1;
        if (!lr && prevLr) begin
          check(frameRises == curRatio, "R2 R8 frame length", frameRises, curRatio);
          frameRises = 0;
          framesDone++;
          curDiv = divOf(cfgAtEdge[3:1]);
          curRatio = cfgAtEdge[0] ? 64 : 48;
          if (pendFull) begin
            expL = pendL;
            expR = pendR;
            pendFull = 0;
          end
        end
      end else if (!b) begin
        lowLen++;
      end
      prevB = b; prevLr = lr; prevSd = sd;
    end
  end

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic sendPair(input logic [15:0] l, input logic [15:0] r);
    inLeft = l; inRight = r; inValid = 1'b1;
    pendL = l; pendR = r; pendFull = 1;
    step();
    inValid = 1'b0;
  endtask

  task automatic setCfg(input logic [2:0] d, input logic rl);
    cfgDivSel = d;
    cfgRatioLong = rl;
  endtask

  initial begin
    void'($urandom(7));
    rst = 1'b1;
    repeat (4) step();
    check({bclkOut, lrclkOut, sdataOut, sampleReq} == 4'b0, "R9 reset idle",
          {bclkOut, lrclkOut, sdataOut, sampleReq}, 0);
    curDiv = divOf(cfgDivSel); curRatio = 48;
    expL = 0; expR = 0; pendFull = 0; halfSlot = -1;
    lowLen = 0; highLen = 0; frameRises = 0; framesDone = 0;
    prevB = 0; prevLr = 0; prevSd = 0;
    monOn = 1;
    rst = 1'b0;
    for (int n = 0; framesDone < 36 && !finished; n++) begin
      do step(); while (!sampleReq && !finished);
      repeat ($urandom_range(0, 8)) step();
      case (n)
        0: sendPair(16'h8000, 16'h0001);
        1: sendPair(16'hFFFF, 16'h0000);
        2: ;  // no answer: previous pair must repeat (R6)
        3: sendPair(16'hA5A5, 16'h5A5A);
        default: if ($urandom_range(0, 3) != 0)
                   sendPair(16'($urandom), 16'($urandom));
      endcase
      if (n == 1) setCfg(3'd7, 1'b1);        // clamp code, long frame
      else if (n == 3) setCfg(3'd2, 1'b0);
      else if (n == 5) setCfg(3'd4, 1'b1);
      else if (n >= 6 && $urandom_range(0, 1) == 1) begin
        repeat ($urandom_range(0, 40)) step();
        setCfg(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      end
    end
    endRun();
  end

  initial begin
    wait (cycles >= 180000);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      endRun();
    end
  end

endmodule